// File: doc/BRIEF.md
# Raster Timing Generator with Vertical-Blank Interrupt

This block paces a 256x224 raster. It counts dots within each scanline, scanlines within each frame, and the frames completed since reset. From these counters it derives a vertical-blank level and a horizontal-blank level, and it exports all three counters for debug.

When the raster enters the first vertical-blank line, the block sets an interrupt flag. If the CPU has enabled the interrupt, the block also emits a one-clock non-maskable interrupt request. A small CPU register port provides one write register, which holds the interrupt enable. It also provides two status reads: the interrupt flag, and the blanking levels. Status reads are combinational, so a read returns the state held before the current clock edge.

Top module: `raster_timer`

## Requirements
- R1: The dot counter steps by one on every clock from 0 to 340 and then returns to 0. The scanline counter advances by one only on that return.
- R2: The scanline counter runs from 0 to 259. On the dot wrap that ends scanline 259, it returns to 0 and the frame counter increments by one.
- R3: The interrupt flag sets on the edge that moves the scanline to 225. It stays set until the scanline returns to 0, and it clears on that edge.
- R4: `nmi_o` is high for exactly one clock, in the cycle where the scanline has just become 225, and only when the interrupt enable held before that edge is 1. A write to the enable on that same edge affects only later frames.
- R5: A clocked write (`wr_en` high) to address 0x4200 loads the interrupt enable from bit 7 of `wr_data`. Writes to any other address leave the enable unchanged.
- R6: A read of address 0x4210 returns 0x80 while the interrupt flag is set, and 0x00 otherwise.
- R7: In a read of address 0x4212, bit 7 is 1 exactly when the scanline is 225 or greater. `vblank_o` carries the same level.
- R8: In a read of address 0x4212, bit 6 is 1 exactly when the dot counter is at least 0x121 or at most 0x15. `hblank_o` carries the same level. All other bits of this read are 0.
- R9: A read of any address other than 0x4210 or 0x4212 returns 0x00.
- R10: While `rst_n` is low, the dot, scanline and frame counters, the interrupt flag, the enable and `nmi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, sampled on the clock edge |
| addr | input | 16 | CPU register address for reads and writes |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| nmi_o | output | 1 | One-clock interrupt request at vertical-blank entry |
| vblank_o | output | 1 | Vertical-blank level |
| hblank_o | output | 1 | Horizontal-blank level |
| cycle_o | output | 9 | Dot counter |
| line_o | output | 9 | Scanline counter |
| frame_o | output | 16 | Completed-frame counter |

## Verification
A CPU write of the interrupt enable can land on the same clock edge that moves the raster into scanline 225. The two events then race for the interrupt decision.

The bench clears the enable in the first frame after its interrupt has fired. In the second frame, it drives a write of 0x80 to 0x4200 in the last dot of scanline 224. It expects no pulse on `nmi_o`, because the enable held before that edge was 0. It also expects the flag to read back set at 0x4210 in the same cycle.

In the first frame, the enable is set well ahead of the boundary, and a pulse is required at the boundary.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 260,
  parameter int VBL_LINE        = 225,
  parameter int HBL_FROM        = 'h121,
  parameter int HBL_UNTIL       = 'h15,
  parameter int FRAME_W         = 16,
  parameter logic [15:0] ADDR_CTRL  = 16'h4200,
  parameter logic [15:0] ADDR_FLAG  = 16'h4210,
  parameter logic [15:0] ADDR_BLANK = 16'h4212
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [15:0]        addr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic               nmi_o,
  output logic               vblank_o,
  output logic               hblank_o,
  output logic [8:0]         cycle_o,
  output logic [8:0]         line_o,
  output logic [FRAME_W-1:0] frame_o
);

  localparam int CW = 9;
  localparam logic [CW-1:0] DOT_LAST  = CW'(DOTS_PER_LINE - 1);
  localparam logic [CW-1:0] LINE_LAST = CW'(LINES_PER_FRAME - 1);
  localparam logic [CW-1:0] VBL_AT    = CW'(VBL_LINE);
  localparam logic [CW-1:0] HBL_LO    = CW'(HBL_FROM);
  localparam logic [CW-1:0] HBL_HI    = CW'(HBL_UNTIL);

  logic [CW-1:0]      cyc_q, line_q;
  logic [FRAME_W-1:0] frame_q;
  logic               flag_q, en_q, nmi_q;

  wire dot_wrap   = (cyc_q == DOT_LAST);
  wire frame_wrap = dot_wrap && (line_q == LINE_LAST);
  wire enter_vbl  = dot_wrap && (line_q == VBL_AT - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      line_q  <= '0;
      frame_q <= '0;
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      cyc_q <= dot_wrap ? '0 : cyc_q + CW'(1);
      nmi_q <= enter_vbl && en_q;
      if (frame_wrap) begin
        line_q  <= '0;
        frame_q <= frame_q + FRAME_W'(1);
        flag_q  <= 1'b0;
      end else if (dot_wrap) begin
        line_q <= line_q + CW'(1);
        if (enter_vbl) flag_q <= 1'b1;
      end
      if (wr_en && addr == ADDR_CTRL) en_q <= wr_data[7];
    end
  end

  assign vblank_o = (line_q >= VBL_AT);
  assign hblank_o = (cyc_q >= HBL_LO) || (cyc_q <= HBL_HI);
  assign nmi_o    = nmi_q;
  assign cycle_o  = cyc_q;
  assign line_o   = line_q;
  assign frame_o  = frame_q;

  always_comb begin
    case (addr)
      ADDR_FLAG:  rd_data = {flag_q, 7'd0};
      ADDR_BLANK: rd_data = {vblank_o, hblank_o, 6'd0};
      default:    rd_data = 8'h00;
    endcase
  end

  assert_dot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= DOT_LAST);
  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_wrap |=> $stable(line_o));
  assert_frame_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (frame_o == $past(frame_o) + FRAME_W'(1)) && line_o == '0);
  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> line_o == VBL_AT && cycle_o == '0);
  assert_pulse_where_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> flag_q && line_o == VBL_AT && cycle_o == '0);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);

endmodule

// File: tb/raster_timer_tb_top.sv
module raster_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [15:0] addr;
  logic [7:0]  wr_data, rd_data;
  logic        nmi_o, vblank_o, hblank_o;
  logic [8:0]  cycle_o, line_o;
  logic [15:0] frame_o;

  int checks = 0, errors = 0, k = 0;
  bit done = 0;

  localparam int LINE = 341;
  localparam int FRAME = 341 * 260;
  localparam int VBL_K = 341 * 225;

  always #5 clk = ~clk;

  raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .nmi_o(nmi_o), .vblank_o(vblank_o), .hblank_o(hblank_o),
    .cycle_o(cycle_o), .line_o(line_o), .frame_o(frame_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", req, k, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #2;
    k += n;
  endtask

  task automatic go(input int target);
    if (target > k) adv(target - k);
  endtask

  task automatic rd(input logic [15:0] a, input string req, input int exp);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    adv(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 cycle", cycle_o, 0);
    chk("R10 line", line_o, 0);
    chk("R10 frame", frame_o, 0);
    chk("R10 nmi", nmi_o, 0);
    rd(16'h4210, "R10 flag", 8'h00);
  endtask

  task automatic t_hblank;
    go(21);  chk("R1 cycle", cycle_o, 21); rd(16'h4212, "R8 edge 0x15", 8'h40);
    go(22);  rd(16'h4212, "R8 0x16", 8'h00); chk("R8 hblank_o", hblank_o, 0);
    rd(16'h4211, "R9 unmapped", 8'h00);
    go(288); rd(16'h4212, "R8 0x120", 8'h00);
    go(289); rd(16'h4212, "R8 0x121", 8'h40);
    go(340); chk("R1 last dot", cycle_o, 340); chk("R1 line held", line_o, 0);
    go(341); chk("R1 dot wrap", cycle_o, 0); chk("R1 line step", line_o, 1);
    rd(16'h4212, "R8 dot 0", 8'h40);
  endtask

  task automatic t_vblank_entry;
    go(VBL_K - 1);
    chk("R4 before", nmi_o, 0);
    rd(16'h4210, "R6 clear", 8'h00);
    rd(16'h4212, "R7 line 224", 8'h40);
    go(VBL_K);
    chk("R3 line", line_o, 225);
    chk("R4 pulse", nmi_o, 1);
    rd(16'h4210, "R6 set", 8'h80);
    rd(16'h4212, "R7 R8 combined", 8'hC0);
    chk("R7 vblank_o", vblank_o, 1);
    go(VBL_K + 1);
    chk("R4 one clock", nmi_o, 0);
    rd(16'h4210, "R3 flag held", 8'h80);
    write_reg(16'h4200, 8'h00);
  endtask

  task automatic t_frame_wrap;
    go(FRAME - 1);
    chk("R2 last line", line_o, 259);
    rd(16'h4210, "R3 held to end", 8'h80);
    go(FRAME);
    chk("R2 line 0", line_o, 0);
    chk("R2 frame", frame_o, 1);
    chk("R2 dot", cycle_o, 0);
    rd(16'h4210, "R3 flag cleared", 8'h00);
    rd(16'h4212, "R7 vblank off", 8'h40);
  endtask

  task automatic t_same_edge;
    write_reg(16'h4201, 8'h80);
    go(FRAME + VBL_K - 1);
    write_reg(16'h4200, 8'h80);
    chk("R4 R5 coincident write no pulse", nmi_o, 0);
    chk("R3 second frame line", line_o, 225);
    rd(16'h4210, "R3 R6 second frame", 8'h80);
    adv(1);
    chk("R4 still quiet", nmi_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 16'h0; wr_data = 8'h0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    k = 0;
    write_reg(16'h4200, 8'h80);
    t_hblank();
    t_vblank_entry();
    t_frame_wrap();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(195000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog at k=%0d: actual timeout expected completion", k);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule